// File: doc/BRIEF.md
# Nibble Table-Read Pointer

A 4-bit datapath often needs constant bytes that are kept in an 8-bit-wide program ROM. This block holds a 12-bit pointer into that ROM and hands the addressed byte back one nibble at a time. Software assembles the pointer from three nibbles, each with its own load strobe. It then issues low-half or high-half reads. The result appears on a 4-bit accumulator output, qualified by a valid flag, one clock after the read strobe. This delay matches the synchronous ROM port.

A high-half read also steps the pointer forward by one. A byte table can therefore be streamed as alternating low and high reads, without reloading the pointer. The ROM holds 3072 bytes. Pointer values past the last byte read as zero, and stepping from the last byte or beyond returns the pointer to the start.

Top module: `nib_table_reader`

## Requirements
- R1: After reset the pointer is 000h, `accValid` is low and `accOut` is 0.
- R2: `ldLo`, `ldMid` and `ldHi` write `wrData` into pointer bits [3:0], [7:4] and [11:8] respectively. Nibbles that are not strobed keep their value. Any combination may be strobed in one cycle.
- R3: `romAddr` always presents the current pointer value.
- R4: A `rdLo` strobe makes `accValid` high in the next cycle, with `accOut` equal to bits [3:0] of the ROM byte at the pointer. The pointer does not change.
- R5: A `rdHi` strobe makes `accValid` high in the next cycle, with `accOut` equal to bits [7:4] of the ROM byte at the pointer. The pointer then holds its old value plus one.
- R6: When a `rdHi` steps a pointer that is BFFh or higher, the pointer becomes 000h.
- R7: A read issued while the pointer is above BFFh returns `accOut` = 0 with `accValid` high.
- R8: When a load strobe and `rdHi` occur in the same cycle, each strobed nibble takes `wrData`. The other nibbles take the stepped value. The read itself uses the pointer from before the step.
- R9: When `rdLo` and `rdHi` occur together, the block behaves exactly as for `rdHi` alone.
- R10: In a cycle that does not follow a read strobe, `accValid` is low and `accOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 4 | Nibble written by the load strobes |
| ldLo | input | 1 | Load pointer bits [3:0] |
| ldMid | input | 1 | Load pointer bits [7:4] |
| ldHi | input | 1 | Load pointer bits [11:8] |
| rdLo | input | 1 | Read low half of ROM byte at pointer |
| rdHi | input | 1 | Read high half, then step pointer |
| romAddr | output | 12 | ROM read address (the pointer) |
| romData | input | 8 | ROM byte, registered one clock after `romAddr` |
| accOut | output | 4 | Nibble returned to the accumulator |
| accValid | output | 1 | `accOut` holds read data this cycle |

## Verification
A nibble load and the post-read step can both act on the pointer in the same cycle, so they collide. The bench forces this collision directly: it strobes `ldLo` together with `rdHi` on a pointer of 0FFh, where the step carries into the upper nibbles. It also mixes all strobes at random over thousands of cycles, with pointers steered near and past BFFh. For every cycle, a bench model computes the expected pointer: step first, then overwrite the strobed nibbles. The bench compares `romAddr` against this model, and compares the returned nibble against the byte at the pre-step pointer.

// File: rtl/ntr_pkg.sv
package ntr_pkg;
  localparam int NIB_W     = 4;
  localparam int PTR_W     = 12;
  localparam int NIB_CNT   = PTR_W / NIB_W;
  localparam int ROM_DEPTH = 3072;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [NIB_CNT-1:0] loadMask;  // one bit per pointer nibble
    logic               bump;      // step pointer after this cycle's read
    logic               capture;   // a read is issued this cycle
    logic               pickHigh;  // the read wants bits of the upper half
  } ntrCtl_t;
endpackage

// File: rtl/ntr_ctrl.sv
module ntr_ctrl
  import ntr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ldLo,
  input  logic    ldMid,
  input  logic    ldHi,
  input  logic    rdLo,
  input  logic    rdHi,
  output ntrCtl_t ctl,
  output logic    validQ,
  output logic    highQ
);
  always_comb begin
    ctl          = '0;
    ctl.loadMask = {ldHi, ldMid, ldLo};
    ctl.capture  = rdLo | rdHi;
    ctl.pickHigh = rdHi;          // high read wins when both are strobed
    ctl.bump     = rdHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      highQ  <= 1'b0;
    end else begin
      validQ <= ctl.capture;
      highQ  <= ctl.pickHigh;
    end
  end
endmodule

// File: rtl/ntr_datapath.sv
module ntr_datapath
  import ntr_pkg::*;
#(
  parameter int NibW     = NIB_W,
  parameter int PtrW     = PTR_W,
  parameter int RomDepth = ROM_DEPTH
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NibW-1:0] wrData,
  input  ntrCtl_t         ctl,
  input  logic            validQ,
  input  logic            highQ,
  input  logic [2*NibW-1:0] romData,
  output logic [PtrW-1:0] romAddr,
  output logic [NibW-1:0] accOut
);
  localparam int NibCnt = PtrW / NibW;
  localparam logic [PtrW-1:0] LastAddr = PtrW'(RomDepth - 1);

  logic [PtrW-1:0] dpQ;
  logic [PtrW-1:0] stepped;
  logic [PtrW-1:0] base;
  logic [PtrW-1:0] dpNext;
  logic            outOfRangeQ;

  assign stepped = (dpQ >= LastAddr) ? '0 : dpQ + PtrW'(1);
  assign base    = ctl.bump ? stepped : dpQ;

  // Per-nibble write overrides the stepped value
  for (genvar g = 0; g < NibCnt; g++) begin : gNib
    assign dpNext[g*NibW +: NibW] = ctl.loadMask[g] ? wrData : base[g*NibW +: NibW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpQ         <= '0;
      outOfRangeQ <= 1'b0;
    end else begin
      dpQ         <= dpNext;
      outOfRangeQ <= ctl.capture && (dpQ > LastAddr);
    end
  end

  assign romAddr = dpQ;

  always_comb begin
    if (!validQ || outOfRangeQ) accOut = '0;
    else if (highQ)             accOut = romData[2*NibW-1:NibW];
    else                        accOut = romData[NibW-1:0];
  end
endmodule

// File: rtl/nib_table_reader.sv
module nib_table_reader
  import ntr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] wrData,
  input  logic             ldLo,
  input  logic             ldMid,
  input  logic             ldHi,
  input  logic             rdLo,
  input  logic             rdHi,
  output logic [PTR_W-1:0] romAddr,
  input  logic [2*NIB_W-1:0] romData,
  output logic [NIB_W-1:0] accOut,
  output logic             accValid
);
  ntrCtl_t ctl;
  logic    highQ;

  ntr_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .ldLo(ldLo), .ldMid(ldMid), .ldHi(ldHi),
    .rdLo(rdLo), .rdHi(rdHi),
    .ctl(ctl), .validQ(accValid), .highQ(highQ)
  );

  ntr_datapath uPath (
    .clk(clk), .rstN(rstN), .wrData(wrData), .ctl(ctl),
    .validQ(accValid), .highQ(highQ), .romData(romData),
    .romAddr(romAddr), .accOut(accOut)
  );
endmodule

// File: rtl/ntr_checker.sv
module ntr_checker
  import ntr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [NIB_W-1:0] wrData,
  input logic             ldLo,
  input logic             ldMid,
  input logic             ldHi,
  input logic             rdLo,
  input logic             rdHi,
  input logic [PTR_W-1:0] romAddr,
  input logic [NIB_W-1:0] accOut,
  input logic             accValid
);
  localparam logic [PTR_W-1:0] LastAddr = PTR_W'(ROM_DEPTH - 1);
  logic anyLoad;
  assign anyLoad = ldLo | ldMid | ldHi;

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rdLo || rdHi) |=> accValid); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(rdLo || rdHi) |=> (!accValid && accOut == '0)); // R10
  AST_LO_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (rdLo && !rdHi && !anyLoad) |=> $stable(romAddr)); // R4
  AST_HI_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (rdHi && !anyLoad && romAddr < LastAddr) |=> romAddr == $past(romAddr) + 12'd1); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdHi && !anyLoad && romAddr >= LastAddr) |=> romAddr == '0); // R6
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((rdLo || rdHi) && romAddr > LastAddr) |=> (accValid && accOut == '0)); // R7
  AST_LOAD_MID: assert property (@(posedge clk) disable iff (!rstN)
    ldMid |=> romAddr[7:4] == $past(wrData)); // R2
  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdHi && ldLo) |=> romAddr[3:0] == $past(wrData)); // R8
endmodule

bind nib_table_reader ntr_checker uChk (
  .clk(clk), .rstN(rstN), .wrData(wrData),
  .ldLo(ldLo), .ldMid(ldMid), .ldHi(ldHi),
  .rdLo(rdLo), .rdHi(rdHi),
  .romAddr(romAddr), .accOut(accOut), .accValid(accValid)
);

// File: tb/nib_table_reader_test.sv
`timescale 1ns/1ps
module nib_table_reader_test;
  localparam logic [11:0] LAST = 12'hBFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  wrData = '0;
  logic        ldLo = 0, ldMid = 0, ldHi = 0, rdLo = 0, rdHi = 0;
  logic [11:0] romAddr;
  logic [7:0]  romData = '0;
  logic [3:0]  accOut;
  logic        accValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [11:0] mDp = '0;

  always #2.5 clk = ~clk;

  nib_table_reader uut (
    .clk(clk), .rstN(rstN), .wrData(wrData),
    .ldLo(ldLo), .ldMid(ldMid), .ldHi(ldHi),
    .rdLo(rdLo), .rdHi(rdHi), .romAddr(romAddr),
    .romData(romData), .accOut(accOut), .accValid(accValid)
  );

  function automatic logic [7:0] romByte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  // Synchronous ROM model
  always @(posedge clk) romData <= romByte(romAddr);

  function automatic logic [11:0] stepPtr(input logic [11:0] p);
    return (p >= LAST) ? 12'h000 : p + 12'd1;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle of strobes, checks at the next negedge
  task automatic doOp(input logic l0, input logic l1, input logic l2,
                      input logic rl, input logic rh, input logic [3:0] wd);
    logic [7:0]  b;
    logic        expV;
    logic [3:0]  expA;
    logic [11:0] nDp;
    string       tag;
    bit          anyLd;
    anyLd = l0 | l1 | l2;
    ldLo = l0; ldMid = l1; ldHi = l2; rdLo = rl; rdHi = rh; wrData = wd;
    b    = romByte(mDp);
    expV = rl | rh;
    expA = (!expV || mDp > LAST) ? 4'h0 : (rh ? b[7:4] : b[3:0]);
    nDp  = rh ? stepPtr(mDp) : mDp;
    if (l0) nDp[3:0]  = wd;
    if (l1) nDp[7:4]  = wd;
    if (l2) nDp[11:8] = wd;
    if (anyLd && rh)            tag = "R8";
    else if (rl && rh)          tag = "R9";
    else if (expV && mDp > LAST) tag = "R7";
    else if (rh && mDp >= LAST) tag = "R6";
    else if (rh)                tag = "R5";
    else if (rl)                tag = "R4";
    else if (anyLd)             tag = "R2";
    else                        tag = "R10";
    @(negedge clk);
    ldLo = 0; ldMid = 0; ldHi = 0; rdLo = 0; rdHi = 0;
    mDp = nDp;
    check({tag, " valid"}, {11'd0, accValid}, {11'd0, expV});
    check({tag, " data"},  {8'd0, accOut},    {8'd0, expA});
    check({tag, " R3 addr"}, romAddr, mDp);
  endtask

  task automatic loadPtr(input logic [11:0] p);
    doOp(1, 0, 0, 0, 0, p[3:0]);
    doOp(0, 1, 0, 0, 0, p[7:4]);
    doOp(0, 0, 1, 0, 0, p[11:8]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 addr",  romAddr, 12'h000);
    check("R1 valid", {11'd0, accValid}, 12'd0);
    check("R1 data",  {8'd0, accOut}, 12'd0);

    loadPtr(12'h235);               // R2
    doOp(0, 0, 0, 1, 0, 4'h0);      // R4
    doOp(0, 0, 0, 1, 0, 4'h0);      // R4 repeat, pointer held
    doOp(0, 0, 0, 0, 1, 4'h0);      // R5
    doOp(0, 0, 0, 0, 0, 4'h0);      // R10
    doOp(1, 1, 0, 0, 0, 4'hF);      // R2 two nibbles at once
    doOp(0, 0, 1, 0, 0, 4'hB);      // pointer BFFh
    doOp(0, 0, 0, 1, 0, 4'h0);      // last valid byte
    doOp(0, 0, 0, 0, 1, 4'h0);      // R6 wrap
    loadPtr(12'hC05);
    doOp(0, 0, 0, 1, 0, 4'h0);      // R7 low read beyond end
    doOp(0, 0, 0, 0, 1, 4'h0);      // R7 and R6 from above end
    loadPtr(12'h0FF);
    doOp(1, 0, 0, 0, 1, 4'h9);      // R8 load meets carry
    doOp(0, 1, 1, 0, 1, 4'h4);      // R8 upper nibbles
    doOp(0, 0, 0, 1, 1, 4'h0);      // R9 both reads

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] wd;
      logic l0, l1, l2, rl, rh;
      wd = 4'($urandom);
      l0 = ($urandom % 6) == 0;
      l1 = ($urandom % 8) == 0;
      l2 = ($urandom % 8) == 0;
      if (l2 && ($urandom % 2)) wd = 4'hB + 4'($urandom % 5);
      rl = ($urandom % 3) == 0;
      rh = ($urandom % 3) == 0;
      doOp(l0, l1, l2, rl, rh, wd);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule